// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

This block pairs two eight-line priority interrupt controllers. One acts as master and drives the single interrupt request to the processor core. The other is an internal slave whose own request feeds the master's line 2. Each controller holds a pending-request register, an in-service register and a mask register. It picks the most urgent unmasked request and answers a two-pulse acknowledge with an 8-bit vector: the programmed base in the upper five bits and the winning line number in the lower three.

Software configures either controller through a small write port. A select bit chooses the controller and a 2-bit address chooses the field. Software ends each service routine with an end-of-interrupt command. A combinational read port returns the pending, in-service and mask registers, and a poll word that names the best pending request without acknowledging it. Each controller can be set to edge or level triggering. Each can run in fully nested priority or in special mask mode, where a lower line may interrupt a higher one that is being serviced.

Top module: `pic_cascade`

## Requirements
- R1: After reset, `intReq` and `vectorValid` are low, and both controllers read pending 0x00, in-service 0x00 and mask 0xFF. Read address 0 gives the pending register, 1 gives in-service, 2 gives mask and 3 gives the poll word. `rdSlave` high selects the slave.
- R2: A write to address 2 loads the mask. A set bit stops that line from requesting, and clearing the bit lets the line request again.
- R3: Under fully nested priority, line 0 is the most urgent and line 7 the least. A request reaches `intReq` only when the best unmasked pending line is more urgent than every in-service bit.
- R4: In edge mode (address 0, data bit 0 = 0, the reset default), a 0-to-1 change on a line sets its pending bit. A line that stays high after its acknowledge does not request again.
- R5: In level mode (address 0, data bit 0 = 1), the pending bit follows the line. A line held high requests again once its in-service bit is cleared, and lowering the line withdraws the request.
- R6: The first `intAck` pulse clears the winning pending bit and sets the matching in-service bit. The cycle after the second pulse, `vectorValid` is high for exactly one cycle. At that point `vector` holds the base (data bits 7:3 of the last write to address 1) with the line number in bits 2:0.
- R7: A slave request appears as a master line-2 request, and the master's external line 2 is ignored. Acknowledging it sets master in-service bit 2 and the slave's in-service bit, and the vector comes from the slave. Between the two pulses, `cascadeValid` is high and `cascadeId` is 2.
- R8: A write to address 3 with data bits 7:5 = 001 is a non-specific EOI. It clears the most urgent in-service bit, and it has no effect while special mask mode is on.
- R9: A write to address 3 with data bits 7:5 = 011 is a specific EOI. It clears the in-service bit named by data bits 2:0.
- R10: Address-3 command 110 turns special mask mode on and 101 turns it off. While the mode is on, an in-service bit blocks only its own line, so a less urgent line may request.
- R11: Read address 3 returns {1, 0000, line} for the line that would win, or 0x00 when nothing would request. Reading it changes no register.
- R12: A first pulse while the controller has no request sets no in-service bit, and the vector is base with bits 2:0 = 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Write strobe for the configuration port |
| cfgSlave | input | 1 | Write targets the slave when high |
| cfgAddr | input | 2 | Field: 0 trigger, 1 base, 2 mask, 3 command |
| cfgData | input | 8 | Write data |
| rdSlave | input | 1 | Read targets the slave when high |
| rdAddr | input | 2 | Read field: 0 pending, 1 in-service, 2 mask, 3 poll |
| rdData | output | 8 | Read data (combinational) |
| irqMaster | input | 8 | Master request lines (bit 2 unused) |
| irqSlave | input | 8 | Slave request lines |
| intReq | output | 1 | Interrupt request to the core |
| intAck | input | 1 | Acknowledge pulse, two per sequence |
| vector | output | 8 | Vector, valid with vectorValid |
| vectorValid | output | 1 | One-cycle strobe after the second acknowledge |
| cascadeId | output | 3 | Slave identity during a slave acknowledge |
| cascadeValid | output | 1 | cascadeId is meaningful |

## Verification
Several properties are checked on every clock. Under nested priority, no request may pass an equal or more urgent in-service bit. An accepted acknowledge must set the in-service bit of the line it took. A non-specific EOI must leave the in-service register alone in special mask mode. The vector strobe must be a single cycle that follows only a second pulse. A rise of the cascade flag must trace back to a master line-2 win. Whether the right vector value and the right register contents appear needs the bench's scenarios: the priority table, edge and level re-request behaviour, nested preemption, both EOI kinds, special mask mode, a slave round trip, a spurious acknowledge and side-effect-free polling.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int LINES  = 8;
  localparam int LVL_W  = $clog2(LINES);
  localparam int BASE_W = 8 - LVL_W;

  localparam logic [1:0] ADDR_TRIG = 2'd0;
  localparam logic [1:0] ADDR_BASE = 2'd1;
  localparam logic [1:0] ADDR_MASK = 2'd2;
  localparam logic [1:0] ADDR_CMD  = 2'd3;

  localparam logic [2:0] CMD_EOI     = 3'b001;
  localparam logic [2:0] CMD_SEOI    = 3'b011;
  localparam logic [2:0] CMD_SMM_ON  = 3'b110;
  localparam logic [2:0] CMD_SMM_OFF = 3'b101;

  typedef logic [LINES-1:0] lineVec_t;
  typedef logic [LVL_W-1:0] lvl_t;

  typedef struct packed {
    logic              wrTrig;
    logic              trigLevel;
    logic              wrBase;
    logic [BASE_W-1:0] base;
    logic              wrMask;
    lineVec_t          mask;
    logic              eoiAny;
    logic              eoiSpec;
    lvl_t              eoiLvl;
    logic              smmSet;
    logic              smmClr;
    logic              ackTake;
  } strobe_t;

  // index of the most urgent (lowest numbered) set bit, 0 if none
  function automatic lvl_t firstSet(input lineVec_t v);
    lvl_t r;
    r = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (v[i]) r = lvl_t'(i);
    return r;
  endfunction
endpackage

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  lineVec_t          lineIn,
  output logic              reqOut,
  output lvl_t              winLvl,
  output lineVec_t          irrQ,
  output lineVec_t          isrQ,
  output lineVec_t          imrQ,
  output logic [BASE_W-1:0] baseQ
);
  logic              levelMode, smm;
  logic [BASE_W-1:0] base;
  lineVec_t          irr, isr, imr, prevIn;
  lineVec_t          candidate, rise, takeMask, eoiClr;
  lvl_t              svcLvl;

  always_comb begin
    candidate = irr & ~imr;
    if (smm) candidate = candidate & ~isr;
    winLvl = firstSet(candidate);
    svcLvl = firstSet(isr);
    if (smm || isr == '0) reqOut = |candidate;
    else                  reqOut = (|candidate) && (winLvl < svcLvl);
    rise     = lineIn & ~prevIn;
    takeMask = (strb.ackTake && reqOut) ? (lineVec_t'(1) << winLvl) : '0;
    eoiClr   = '0;
    if (strb.eoiSpec)
      eoiClr = lineVec_t'(1) << strb.eoiLvl;
    else if (strb.eoiAny && !smm && isr != '0)
      eoiClr = lineVec_t'(1) << svcLvl;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelMode <= 1'b0;
      smm       <= 1'b0;
      base      <= '0;
      irr       <= '0;
      isr       <= '0;
      imr       <= '1;
      prevIn    <= '0;
    end else begin
      prevIn <= lineIn;
      if (strb.wrTrig) levelMode <= strb.trigLevel;
      if (strb.wrBase) base      <= strb.base;
      if (strb.wrMask) imr       <= strb.mask;
      if (strb.smmSet) smm <= 1'b1;
      else if (strb.smmClr) smm <= 1'b0;
      if (levelMode) irr <= lineIn & ~takeMask;
      else           irr <= (irr & ~takeMask) | rise;
      isr <= (isr & ~eoiClr) | takeMask;
    end
  end

  assign irrQ  = irr;
  assign isrQ  = isr;
  assign imrQ  = imr;
  assign baseQ = base;

  // bits at or above the winner's urgency
  lineVec_t upToWin;
  always_comb upToWin = ((lineVec_t'(1) << winLvl) << 1) - lineVec_t'(1);

  a_r3_nested_block: assert property (@(posedge clk) disable iff (!rstN)
    (!smm && reqOut) |-> ((isr & upToWin) == '0));

  a_r6_isr_set: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ackTake && reqOut) |=> isr[$past(winLvl)]);

  a_r8_smm_eoi_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eoiAny && !strb.eoiSpec && smm && !strb.ackTake) |=> (isr == $past(isr)));
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int SLAVE_IR = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic              cfgSlave,
  input  logic [1:0]        cfgAddr,
  input  logic [7:0]        cfgData,
  input  logic              intAck,
  input  logic              mReq,
  input  lvl_t              mWin,
  input  logic [BASE_W-1:0] mBase,
  input  logic              sReq,
  input  lvl_t              sWin,
  input  logic [BASE_W-1:0] sBase,
  output strobe_t           mStrb,
  output strobe_t           sStrb,
  output logic [7:0]        vector,
  output logic              vectorValid,
  output logic [LVL_W-1:0]  cascadeId,
  output logic              cascadeValid
);
  localparam lvl_t SLV = lvl_t'(SLAVE_IR);

  strobe_t    cmd;
  logic       ackPhase, casHold, takeNow, slaveWin;
  logic [7:0] vecHold;

  always_comb begin
    cmd = '0;
    if (cfgWr) begin
      case (cfgAddr)
        ADDR_TRIG: begin cmd.wrTrig = 1'b1; cmd.trigLevel = cfgData[0]; end
        ADDR_BASE: begin cmd.wrBase = 1'b1; cmd.base = cfgData[7:LVL_W]; end
        ADDR_MASK: begin cmd.wrMask = 1'b1; cmd.mask = cfgData; end
        default: begin
          case (cfgData[7:5])
            CMD_EOI:     cmd.eoiAny = 1'b1;
            CMD_SEOI:    begin cmd.eoiSpec = 1'b1; cmd.eoiLvl = cfgData[LVL_W-1:0]; end
            CMD_SMM_ON:  cmd.smmSet = 1'b1;
            CMD_SMM_OFF: cmd.smmClr = 1'b1;
            default: ;
          endcase
        end
      endcase
    end
    takeNow  = intAck && !ackPhase;
    slaveWin = mReq && (mWin == SLV);
    mStrb = cfgSlave ? '0 : cmd;
    sStrb = cfgSlave ? cmd : '0;
    mStrb.ackTake = takeNow;
    sStrb.ackTake = takeNow && slaveWin;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackPhase    <= 1'b0;
      casHold     <= 1'b0;
      vecHold     <= '0;
      vector      <= '0;
      vectorValid <= 1'b0;
    end else begin
      vectorValid <= 1'b0;
      if (takeNow) begin
        ackPhase <= 1'b1;
        casHold  <= slaveWin;
        if (!mReq)         vecHold <= {mBase, {LVL_W{1'b1}}};
        else if (slaveWin) vecHold <= sReq ? {sBase, sWin} : {sBase, {LVL_W{1'b1}}};
        else               vecHold <= {mBase, mWin};
      end else if (intAck) begin
        ackPhase    <= 1'b0;
        casHold     <= 1'b0;
        vector      <= vecHold;
        vectorValid <= 1'b1;
      end
    end
  end

  assign cascadeValid = ackPhase && casHold;
  assign cascadeId    = cascadeValid ? SLV : '0;

  a_r6_vec_pulse: assert property (@(posedge clk) disable iff (!rstN)
    vectorValid |=> !vectorValid);

  a_r6_two_step: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && ackPhase) |=> (vectorValid && !ackPhase));

  a_r7_cascade_origin: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cascadeValid) |-> ($past(intAck) && $past(mReq) && $past(mWin) == SLV));
endmodule

// File: rtl/pic_cascade.sv
module pic_cascade
  import pic_pkg::*;
#(
  parameter int SLAVE_IR = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic             cfgSlave,
  input  logic [1:0]       cfgAddr,
  input  logic [7:0]       cfgData,
  input  logic             rdSlave,
  input  logic [1:0]       rdAddr,
  output logic [7:0]       rdData,
  input  logic [7:0]       irqMaster,
  input  logic [7:0]       irqSlave,
  output logic             intReq,
  input  logic             intAck,
  output logic [7:0]       vector,
  output logic             vectorValid,
  output logic [2:0]       cascadeId,
  output logic             cascadeValid
);
  localparam int UNITS = 2;

  strobe_t           strb     [UNITS];
  lineVec_t          unitIn   [UNITS];
  logic              unitReq  [UNITS];
  lvl_t              unitWin  [UNITS];
  lineVec_t          unitIrr  [UNITS];
  lineVec_t          unitIsr  [UNITS];
  lineVec_t          unitImr  [UNITS];
  logic [BASE_W-1:0] unitBase [UNITS];

  always_comb begin
    unitIn[0]           = irqMaster;
    unitIn[0][SLAVE_IR] = unitReq[1];
    unitIn[1]           = irqSlave;
  end

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    pic_core i_core (
      .clk(clk), .rstN(rstN), .strb(strb[u]), .lineIn(unitIn[u]),
      .reqOut(unitReq[u]), .winLvl(unitWin[u]), .irrQ(unitIrr[u]),
      .isrQ(unitIsr[u]), .imrQ(unitImr[u]), .baseQ(unitBase[u])
    );
  end

  pic_ctrl #(.SLAVE_IR(SLAVE_IR)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgSlave(cfgSlave),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .intAck(intAck),
    .mReq(unitReq[0]), .mWin(unitWin[0]), .mBase(unitBase[0]),
    .sReq(unitReq[1]), .sWin(unitWin[1]), .sBase(unitBase[1]),
    .mStrb(strb[0]), .sStrb(strb[1]), .vector(vector),
    .vectorValid(vectorValid), .cascadeId(cascadeId), .cascadeValid(cascadeValid)
  );

  assign intReq = unitReq[0];

  always_comb begin
    int sel;
    sel = rdSlave ? 1 : 0;
    case (rdAddr)
      2'd0:    rdData = unitIrr[sel];
      2'd1:    rdData = unitIsr[sel];
      2'd2:    rdData = unitImr[sel];
      default: rdData = unitReq[sel] ? {1'b1, 4'b0000, unitWin[sel]} : 8'h00;
    endcase
  end
endmodule

// File: tb/test_pic_cascade.sv
module test_pic_cascade;
  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWr = 0, cfgSlave = 0, rdSlave = 0, intAck = 0;
  logic [1:0] cfgAddr = 0, rdAddr = 0;
  logic [7:0] cfgData = 0, irqMaster = 0, irqSlave = 0;
  logic [7:0] rdData, vector;
  logic intReq, vectorValid, cascadeValid;
  logic [2:0] cascadeId;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  pic_cascade i_pic_cascade (.*);

  // {mask, lines, expected request, expected line}
  localparam logic [19:0] TBL [6] = '{
    {8'h00, 8'h00, 1'b0, 3'd0}, {8'h00, 8'h81, 1'b1, 3'd0},
    {8'h00, 8'h88, 1'b1, 3'd3}, {8'h08, 8'h88, 1'b1, 3'd7},
    {8'hFF, 8'hFB, 1'b0, 3'd0}, {8'h01, 8'h03, 1'b1, 3'd1}};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cfgWr = 1; cfgSlave = s; cfgAddr = a; cfgData = d;
    @(negedge clk); cfgWr = 0;
  endtask

  task automatic rd(input logic s, input logic [1:0] a, output logic [7:0] d);
    rdSlave = s; rdAddr = a; #1 d = rdData;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic ackSeq(output logic [7:0] vec, output logic casV, output logic [2:0] casI,
                        output logic vv);
    @(negedge clk); intAck = 1;
    @(negedge clk); intAck = 0; casV = cascadeValid; casI = cascadeId;
    @(negedge clk); intAck = 1;
    @(negedge clk); intAck = 0; vec = vector; vv = vectorValid;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d, vec;
    logic casV, vv;
    logic [2:0] casI;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 intReq", {7'b0, intReq}, 8'h00);
    chk("R1 vectorValid", {7'b0, vectorValid}, 8'h00);
    rd(0, 2, d); chk("R1 master mask", d, 8'hFF);
    rd(1, 2, d); chk("R1 slave mask", d, 8'hFF);
    rd(0, 0, d); chk("R1 master pending", d, 8'h00);
    rd(1, 1, d); chk("R1 slave in-service", d, 8'h00);

    wr(0, 1, 8'h20);
    wr(0, 0, 8'h01);
    // R2 R3 R11 priority table in level mode
    for (int k = 0; k < 6; k++) begin
      wr(0, 2, TBL[k][19:12]);
      irqMaster = TBL[k][11:4];
      settle();
      chk($sformatf("R3 R2 intReq row %0d", k), {7'b0, intReq}, {7'b0, TBL[k][3]});
      rd(0, 3, d);
      chk($sformatf("R11 poll row %0d", k), d, TBL[k][3] ? {5'b10000, TBL[k][2:0]} : 8'h00);
    end
    wr(0, 2, 8'h00);

    // R6 acknowledge in level mode
    irqMaster = 8'h10; settle();
    ackSeq(vec, casV, casI, vv);
    chk("R6 vectorValid", {7'b0, vv}, 8'h01);
    chk("R6 vector", vec, 8'h24);
    chk("R7 no cascade for master line", {7'b0, casV}, 8'h00);
    @(negedge clk);
    chk("R6 strobe single cycle", {7'b0, vectorValid}, 8'h00);
    rd(0, 1, d); chk("R6 in-service set", d, 8'h10);
    chk("R3 same line blocked", {7'b0, intReq}, 8'h00);
    irqMaster = 8'h12; settle();
    chk("R3 urgent preempts", {7'b0, intReq}, 8'h01);
    rd(0, 3, d); chk("R11 poll preempt", d, 8'h81);
    irqMaster = 8'h10;
    wr(0, 3, 8'h20); settle();
    rd(0, 1, d); chk("R8 nonspecific EOI", d, 8'h00);
    chk("R5 level re-request", {7'b0, intReq}, 8'h01);
    irqMaster = 8'h00; settle();
    chk("R5 level withdraw", {7'b0, intReq}, 8'h00);

    // R4 edge mode
    wr(0, 0, 8'h00);
    irqMaster = 8'h40; settle();
    rd(0, 3, d); chk("R4 edge request", d, 8'h86);
    ackSeq(vec, casV, casI, vv);
    chk("R6 vector line 6", vec, 8'h26);
    wr(0, 3, 8'h20); settle();
    chk("R4 held line no re-request", {7'b0, intReq}, 8'h00);
    rd(0, 0, d); chk("R4 pending clear", d, 8'h00);
    irqMaster = 8'h00;

    // R9 specific EOI with nesting
    irqMaster = 8'h20; settle();
    ackSeq(vec, casV, casI, vv);
    irqMaster = 8'h21; settle();
    chk("R3 nested request", {7'b0, intReq}, 8'h01);
    ackSeq(vec, casV, casI, vv);
    chk("R6 vector line 0", vec, 8'h20);
    rd(0, 1, d); chk("R6 two in service", d, 8'h21);
    wr(0, 3, 8'h65); settle();
    rd(0, 1, d); chk("R9 specific EOI", d, 8'h01);
    wr(0, 3, 8'h20); settle();
    rd(0, 1, d); chk("R8 nonspecific EOI", d, 8'h00);
    irqMaster = 8'h00;

    // R10 special mask mode
    wr(0, 3, 8'hC0);
    irqMaster = 8'h02; settle();
    ackSeq(vec, casV, casI, vv);
    irqMaster = 8'h42; settle();
    chk("R10 lower line allowed", {7'b0, intReq}, 8'h01);
    rd(0, 3, d); chk("R10 poll lower line", d, 8'h86);
    wr(0, 3, 8'h20); settle();
    rd(0, 1, d); chk("R8 EOI ignored in special mask", d, 8'h02);
    ackSeq(vec, casV, casI, vv);
    chk("R10 vector", vec, 8'h26);
    rd(0, 1, d); chk("R10 both in service", d, 8'h42);
    wr(0, 3, 8'h66); wr(0, 3, 8'h61); settle();
    rd(0, 1, d); chk("R9 specific EOI clears all", d, 8'h00);
    wr(0, 3, 8'hA0);
    irqMaster = 8'h00;

    // R7 cascade
    wr(1, 1, 8'h70);
    wr(1, 2, 8'h00);
    irqSlave = 8'h08; settle();
    rd(0, 3, d); chk("R7 slave seen on line 2", d, 8'h82);
    ackSeq(vec, casV, casI, vv);
    chk("R7 cascadeValid", {7'b0, casV}, 8'h01);
    chk("R7 cascadeId", {5'b0, casI}, 8'h02);
    chk("R7 slave vector", vec, 8'h73);
    rd(0, 1, d); chk("R7 master in-service", d, 8'h04);
    rd(1, 1, d); chk("R7 slave in-service", d, 8'h08);
    wr(1, 3, 8'h20); wr(0, 3, 8'h20); settle();
    rd(1, 1, d); chk("R8 slave EOI", d, 8'h00);

    // R12 spurious
    chk("R12 idle", {7'b0, intReq}, 8'h00);
    ackSeq(vec, casV, casI, vv);
    chk("R12 spurious vector", vec, 8'h27);
    rd(0, 1, d); chk("R12 no in-service", d, 8'h00);

    // R11 poll has no side effect
    irqMaster = 8'h08; settle();
    rd(0, 3, d); chk("R11 poll first", d, 8'h83);
    @(negedge clk);
    rd(0, 3, d); chk("R11 poll second", d, 8'h83);
    rd(0, 0, d); chk("R11 pending kept", d, 8'h08);
    rd(0, 1, d); chk("R11 in-service untouched", d, 8'h00);

    summary();
    $finish;
  end
endmodule